// File: doc/BRIEF.md
# D-Channel Priority Access Arbiter

This block decides when a local station may place bits on a shared 16 kbit/s D-channel that several stations contend for. Once per D-bit slot it looks at the echoed bit, either the E echo from the line or the upstream D bit seen on the time-division bus. It keeps a count of consecutive 1s and grants the channel when that count reaches the threshold for the selected priority class. The threshold is one higher after the station has just sent a frame successfully. It returns to the normal value once the raised count has been seen.

While granted, the block forwards the station's transmit bit to the D output. Each slot it compares the echo with the bit that was sent. On a mismatch it withdraws at once: it drives 1s again, flags a collision and starts counting from zero. A bus-free flag gives local controllers a handshake: it is high while the channel is not held by this station. With the collision mode switched off the block steps aside, and requests pass straight through.

Top module: `d_arbiter`

## Requirements
- R1: After reset, grant is 0, d_out is 1, bac_out is 1 and collision is 0.
- R2: With prio_hi=0 and tx_req=1, grant rises right after the slot in which the run of consecutive 1 echoes, counting that slot's own echo, reaches 8. After 7 such slots it is still 0.
- R3: With prio_hi=1 the run needed is 10: no grant after 9 ones, grant after the 10th.
- R4: An echo of 0 in any slot while not granted restarts the run from zero.
- R5: After a frame ends successfully (the slot with tx_end=1 and every echo in the frame equal to the sent bit), the run needed rises by one (9 for class 1, 11 for class 2). The raised level drops back to normal in the slot where the raised run is reached, whether or not a grant is taken then. The run count is zero right after any grant.
- R6: In a granted slot where echo_bit differs from the transmitted bit, grant falls after that slot. collision is 1 for exactly one cycle, and the run restarts from zero at the unchanged level.
- R7: d_out is 1 whenever grant is 0, and equals tx_bit whenever grant is 1.
- R8: bac_out is 0 exactly while grant is 1 (1 means the channel is free).
- R9: The run counter saturates: after any number of consecutive ones beyond the largest threshold, the next slot with a 1 echo and tx_req=1 grants.
- R10: With coll_mode=0, grant equals tx_req without delay and no counting takes place. Run, level and send state are cleared, so re-enabling starts from a fresh run.
- R11: With coll_mode=1 held, grant changes only in the cycle after a slot_en pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_en | input | 1 | One-cycle strobe per D-bit slot |
| coll_mode | input | 1 | 1 selects priority/collision arbitration |
| prio_hi | input | 1 | 0 = class 1 (8 ones), 1 = class 2 (10 ones) |
| tx_req | input | 1 | Local controller requests the channel |
| tx_bit | input | 1 | D bit the station wants to send |
| tx_end | input | 1 | Marks the last bit of the frame |
| echo_bit | input | 1 | Echoed E bit / upstream D bit for this slot |
| grant | output | 1 | Station holds the channel |
| d_out | output | 1 | D bit driven toward the line |
| bac_out | output | 1 | 1 = channel free, 0 = held by this station |
| collision | output | 1 | One-cycle pulse on withdrawal |

## Verification
The bench walks each class to one short of its threshold and then to the threshold. A design that compared the count before the current echo would grant one slot late, and one with a wrong constant would grant early. A zero placed in the middle of a run catches a counter that is only cleared at grant. A frame ending successfully must cost one extra slot next time, and a reached raised run with no request must restore the normal level. Getting this wrong shows up as an early grant or a permanent penalty. Collisions must drop the grant in the same slot and keep the normal level, and a long run of ones must not wrap the counter and lose eligibility.

// File: rtl/d_arbiter.sv
module d_arbiter #(
  parameter int CLASS1_ONES = 8,
  parameter int CLASS2_ONES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_en,
  input  logic coll_mode,
  input  logic prio_hi,
  input  logic tx_req,
  input  logic tx_bit,
  input  logic tx_end,
  input  logic echo_bit,
  output logic grant,
  output logic d_out,
  output logic bac_out,
  output logic collision
);
  localparam int TOP = ((CLASS2_ONES > CLASS1_ONES) ? CLASS2_ONES : CLASS1_ONES) + 1;
  localparam int CW  = $clog2(TOP + 1);

  logic          sending, lowered;
  logic [CW-1:0] ones, ones_nx, need;
  logic          win;

  assign need    = prio_hi ? CW'(CLASS2_ONES + (lowered ? 1 : 0))
                           : CW'(CLASS1_ONES + (lowered ? 1 : 0));
  assign ones_nx = !echo_bit ? '0 : ((ones == CW'(TOP)) ? ones : ones + 1'b1);
  assign win     = ones_nx >= need;

  assign grant   = coll_mode ? sending : tx_req;
  assign d_out   = grant ? tx_bit : 1'b1;
  assign bac_out = !grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sending   <= 1'b0;
      lowered   <= 1'b0;
      ones      <= '0;
      collision <= 1'b0;
    end else if (!coll_mode) begin
      sending   <= 1'b0;
      lowered   <= 1'b0;
      ones      <= '0;
      collision <= 1'b0;
    end else begin
      collision <= 1'b0;
      if (slot_en) begin
        if (sending) begin
          if (echo_bit != tx_bit) begin
            sending   <= 1'b0;
            ones      <= '0;
            collision <= 1'b1;
          end else if (tx_end) begin
            sending <= 1'b0;
            lowered <= 1'b1;
            ones    <= '0;
          end
        end else begin
          ones <= ones_nx;
          if (win) begin
            lowered <= 1'b0;
            if (tx_req) begin
              sending <= 1'b1;
              ones    <= '0;
            end
          end
        end
      end
    end
  end
endmodule

module d_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic slot_en,
  input logic coll_mode,
  input logic tx_bit,
  input logic echo_bit,
  input logic grant,
  input logic d_out,
  input logic bac_out,
  input logic collision
);
  assert_mismatch_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_mode && slot_en && grant && (echo_bit != tx_bit)) |=> (!grant || !coll_mode));

  assert_collision_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    collision |=> !collision);

  assert_idle_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> d_out);

  assert_bac_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bac_out |-> !grant);

  assert_grant_after_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant) && coll_mode && $past(coll_mode)) |-> ($past(slot_en) && $past(echo_bit)));

  assert_grant_on_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_mode && !slot_en) |=> (!coll_mode || $stable(grant)));
endmodule

bind d_arbiter d_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .coll_mode(coll_mode),
  .tx_bit(tx_bit), .echo_bit(echo_bit), .grant(grant), .d_out(d_out),
  .bac_out(bac_out), .collision(collision)
);

// File: tb/tb_d_arbiter.sv
module tb_d_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_en = 1'b0, coll_mode = 1'b1, prio_hi = 1'b0;
  logic tx_req = 1'b0, tx_bit = 1'b1, tx_end = 1'b0, echo_bit = 1'b1;
  logic grant, d_out, bac_out, collision;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  d_arbiter dut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .coll_mode(coll_mode),
    .prio_hi(prio_hi), .tx_req(tx_req), .tx_bit(tx_bit), .tx_end(tx_end),
    .echo_bit(echo_bit), .grant(grant), .d_out(d_out), .bac_out(bac_out),
    .collision(collision)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_en = 1'b0; coll_mode = 1'b1; prio_hi = 1'b0;
    tx_req = 1'b0; tx_bit = 1'b1; tx_end = 1'b0; echo_bit = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic slot(input logic e, input logic d, input logic last);
    echo_bit = e; tx_bit = d; tx_end = last; slot_en = 1'b1;
    @(negedge clk);
    slot_en = 1'b0; tx_end = 1'b0;
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) slot(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant", grant, 1'b0);
    chk("R1 d_out", d_out, 1'b1);
    chk("R1 bac_out", bac_out, 1'b1);
    chk("R1 collision", collision, 1'b0);
  endtask

  task automatic t_class1();
    do_reset();
    tx_req = 1'b1;
    ones(7);
    chk("R2 no grant after 7", grant, 1'b0);
    ones(1);
    chk("R2 grant after 8", grant, 1'b1);
    chk("R8 bac low while granted", bac_out, 1'b0);
    tx_bit = 1'b0; #1;
    chk("R7 d_out follows tx_bit", d_out, 1'b0);
    tx_bit = 1'b1; #1;
    chk("R7 d_out follows tx_bit 1", d_out, 1'b1);
  endtask

  task automatic t_class2();
    do_reset();
    prio_hi = 1'b1; tx_req = 1'b1;
    ones(9);
    chk("R3 no grant after 9", grant, 1'b0);
    ones(1);
    chk("R3 grant after 10", grant, 1'b1);
  endtask

  task automatic t_zero();
    do_reset();
    tx_req = 1'b1;
    ones(5);
    slot(1'b0, 1'b1, 1'b0);
    ones(7);
    chk("R4 run restarted by zero", grant, 1'b0);
    ones(1);
    chk("R4 grant after fresh 8", grant, 1'b1);
  endtask

  task automatic t_lowered();
    do_reset();
    tx_req = 1'b1;
    ones(8);
    chk("R5 first grant", grant, 1'b1);
    slot(1'b0, 1'b0, 1'b0);
    slot(1'b1, 1'b1, 1'b0);
    slot(1'b0, 1'b0, 1'b1);
    chk("R5 frame ended", grant, 1'b0);
    chk("R8 bac free after frame", bac_out, 1'b1);
    ones(8);
    chk("R5 lowered: no grant after 8", grant, 1'b0);
    ones(1);
    chk("R5 lowered: grant after 9", grant, 1'b1);
    slot(1'b1, 1'b1, 1'b1);
    tx_req = 1'b0;
    ones(9);
    chk("R5 no request, no grant", grant, 1'b0);
    slot(1'b0, 1'b1, 1'b0);
    tx_req = 1'b1;
    ones(7);
    chk("R5 back to normal: none after 7", grant, 1'b0);
    ones(1);
    chk("R5 back to normal: grant after 8", grant, 1'b1);
  endtask

  task automatic t_collision();
    do_reset();
    tx_req = 1'b1;
    ones(8);
    chk("R6 granted before clash", grant, 1'b1);
    echo_bit = 1'b0; tx_bit = 1'b1; slot_en = 1'b1;
    @(negedge clk);
    slot_en = 1'b0;
    chk("R6 grant dropped", grant, 1'b0);
    chk("R6 collision flagged", collision, 1'b1);
    chk("R7 d_out back to 1", d_out, 1'b1);
    @(negedge clk);
    chk("R6 collision one cycle", collision, 1'b0);
    ones(7);
    chk("R6 count restarted: none after 7", grant, 1'b0);
    ones(1);
    chk("R6 level unchanged: grant after 8", grant, 1'b1);
  endtask

  task automatic t_saturate();
    do_reset();
    prio_hi = 1'b1;
    ones(40);
    chk("R9 no request no grant", grant, 1'b0);
    tx_req = 1'b1;
    ones(1);
    chk("R9 saturated run still grants", grant, 1'b1);
  endtask

  task automatic t_disabled();
    do_reset();
    tx_req = 1'b1;
    ones(5);
    coll_mode = 1'b0; #1;
    chk("R10 grant follows request", grant, 1'b1);
    tx_bit = 1'b0; #1;
    chk("R10 d_out passes tx_bit", d_out, 1'b0);
    tx_req = 1'b0; #1;
    chk("R10 grant drops with request", grant, 1'b0);
    @(negedge clk);
    coll_mode = 1'b1; tx_req = 1'b1;
    ones(3);
    chk("R10 run cleared: no grant after 3", grant, 1'b0);
    ones(4);
    chk("R10 run cleared: no grant after 7", grant, 1'b0);
    ones(1);
    chk("R10 grant after fresh 8", grant, 1'b1);
  endtask

  task automatic t_hold();
    do_reset();
    tx_req = 1'b1;
    ones(8);
    repeat (5) @(negedge clk);
    chk("R11 grant held between slots", grant, 1'b1);
  endtask

  initial begin
    t_reset();
    t_class1();
    t_class2();
    t_zero();
    t_lowered();
    t_collision();
    t_saturate();
    t_disabled();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule